// File: doc/BRIEF.md
# Lockable Logic-Array Control Registers

This block is a small memory-mapped register bank that sits beside an array of sixteen programmable logic elements. Software uses it to drive a 16-bit input word into the elements and to read their outputs back. It can also route any one element output to the start-of-conversion strobe of a data converter. That strobe is gated by an enable bit and fires a single-cycle pulse on each rising edge of the selected output.

A write-once lock freezes the trigger configuration. After the lock bit is set, only the element input word can still change, and only a reset clears the lock. The bus is a plain single-cycle interface. It has a byte address, a write enable and 32-bit write data, and read data is returned combinationally for the address currently presented. The logic elements and the converter are not part of this block.

Top module: `la_ctrl_regs`

## Requirements
- R1: After reset every register is zero: the trigger is disabled with element 0 selected, `elem_in_o` is 0, the lock is clear and `conv_start_o` is 0.
- R2: Offset 0x48 is the trigger register. Bit 4 enables the trigger and bits 3:0 select element 0..15. It reads back with these five bits in place and zero above them.
- R3: Offset 0x4C is the element input word. Write data bits 15:0 drive `elem_in_o`, with bit i going to element i. It reads back bits 15:0, and bits 31:16 read as zero.
- R4: Offset 0x50 returns `elem_out_i` in bits 15:0 in the same cycle, with zero above. Writes to this offset change nothing.
- R5: Offset 0x54 is the lock register. A write with bit 0 = 1 sets the lock. A read of this offset returns zero.
- R6: While locked, writes to 0x48 are discarded, and writes to 0x4C still take effect.
- R7: A write of 0 to 0x54 before locking leaves the block unlocked and still lockable. Once locked, no write clears the lock before reset.
- R8: Let L = enable AND the selected element output, sampled at a clock edge. When L is 1 at edge k and was 0 at edge k-1, `conv_start_o` is 1 for exactly the cycle after edge k. Otherwise it is 0.
- R9: With the enable bit at 0, or with only unselected elements toggling, `conv_start_o` stays 0.
- R10: Reads of any other offset, including unaligned ones, return zero. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset within the block |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| elem_out_i | input | 16 | Current outputs of elements 15..0 |
| elem_in_o | output | 16 | Input word driven into elements 15..0 |
| conv_start_o | output | 1 | One-cycle converter start pulse |

## Verification
Directed sequences first set an element pattern with only the selected bit rising. This shows that the pulse follows the selected element. The same sequences then toggle only neighbouring elements, and then toggle the selected element with the enable bit clear. Together these show that the selection and the gating are both honoured. The lock is tried as three separate cases: a first write of 0, a true lock followed by configuration and input-word writes, and a later write of 0. These tell a one-shot lock apart from a sticky one, and show that the input word stays writable. A seeded random phase mixes writes to all mapped and some unmapped offsets with random element patterns and occasional lock writes. Each cycle is compared against a cycle model in the bench, which catches wrong decode, read-back packing and pulse timing.

// File: rtl/la_regs_pkg.sv
package la_regs_pkg;
  // Byte offsets inside the block
  localparam int unsigned LA_OFF_TRIG = 32'h48;
  localparam int unsigned LA_OFF_DIN  = 32'h4C;
  localparam int unsigned LA_OFF_DOUT = 32'h50;
  localparam int unsigned LA_OFF_LOCK = 32'h54;

  typedef enum logic [2:0] {
    RS_NONE,
    RS_TRIG,
    RS_DIN,
    RS_DOUT,
    RS_LOCK
  } reg_sel_e;
endpackage

// File: rtl/la_addr_decode.sv
module la_addr_decode
  import la_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  always_comb begin
    unique case (addr)
      ADDR_W'(LA_OFF_TRIG): sel = RS_TRIG;
      ADDR_W'(LA_OFF_DIN):  sel = RS_DIN;
      ADDR_W'(LA_OFF_DOUT): sel = RS_DOUT;
      ADDR_W'(LA_OFF_LOCK): sel = RS_LOCK;
      default:              sel = RS_NONE;
    endcase
  end
endmodule

// File: rtl/la_lock_ctrl.sv
module la_lock_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_lock,
  input  logic set_bit,
  output logic locked
);
  logic lock_q;
  logic lock_set_evt;

  // Only a write carrying a 1 consumes the single write
  assign lock_set_evt = wr_lock && set_bit && !lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            lock_q <= 1'b0;
    else if (lock_set_evt) lock_q <= 1'b1;
  end

  assign locked = lock_q;

  // R7: the lock never falls back while out of reset
  p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  // R5, R7: the lock only rises after a write with bit 0 set
  p_lock_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(wr_lock && set_bit));
endmodule

// File: rtl/la_trig_route.sv
module la_trig_route #(
  parameter int unsigned N_ELEM = 16,
  localparam int unsigned SEL_W = $clog2(N_ELEM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [N_ELEM-1:0] elem_out,
  output logic              start
);
  logic [N_ELEM-1:0] hot;
  logic              picked;
  logic              trig_lvl;
  logic              lvl_q;
  logic              start_q;

  // One-hot AND-OR selection of the routed element
  for (genvar g = 0; g < N_ELEM; g++) begin : g_sel
    assign hot[g] = (cfg_sel == SEL_W'(g));
  end

  assign picked   = |(hot & elem_out);
  assign trig_lvl = cfg_en && picked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      lvl_q   <= trig_lvl;
      start_q <= trig_lvl && !lvl_q;
    end
  end

  assign start = start_q;

  // R8: a start pulse lasts a single cycle
  p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);

  // R9: a pulse needs the enable bit set at the edge that launched it
  p_pulse_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> $past(cfg_en));
endmodule

// File: rtl/la_ctrl_regs.sv
module la_ctrl_regs
  import la_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_ELEM = 16,
  localparam int unsigned SEL_W = $clog2(N_ELEM),
  localparam int unsigned EN_BIT = SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_ELEM-1:0] elem_out_i,
  output logic [N_ELEM-1:0] elem_in_o,
  output logic              conv_start_o
);
  reg_sel_e          rsel;
  logic              locked;
  logic              wr_trig;
  logic              wr_din;
  logic              wr_lock;
  logic              trig_en;
  logic [SEL_W-1:0]  trig_sel;
  logic [N_ELEM-1:0] din_q;
  logic              unused_wdata_hi;

  // Pack the trigger fields into a bus word
  function automatic logic [DATA_W-1:0] trig_word(input logic en,
                                                  input logic [SEL_W-1:0] sel);
    logic [DATA_W-1:0] w;
    w            = '0;
    w[SEL_W-1:0] = sel;
    w[EN_BIT]    = en;
    return w;
  endfunction

  // Zero-extend an element-wide word to the bus
  function automatic logic [DATA_W-1:0] elem_word(input logic [N_ELEM-1:0] v);
    return DATA_W'(v);
  endfunction

  la_addr_decode #(.ADDR_W(ADDR_W)) i_dec (
    .addr (bus_addr),
    .sel  (rsel)
  );

  assign wr_trig = bus_we && (rsel == RS_TRIG) && !locked;
  assign wr_din  = bus_we && (rsel == RS_DIN);
  assign wr_lock = bus_we && (rsel == RS_LOCK);

  la_lock_ctrl i_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_lock (wr_lock),
    .set_bit (bus_wdata[0]),
    .locked  (locked)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_en  <= 1'b0;
      trig_sel <= '0;
    end else if (wr_trig) begin
      trig_en  <= bus_wdata[EN_BIT];
      trig_sel <= bus_wdata[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      din_q <= '0;
    else if (wr_din) din_q <= bus_wdata[N_ELEM-1:0];
  end

  assign elem_in_o = din_q;

  always_comb begin
    unique case (rsel)
      RS_TRIG: bus_rdata = trig_word(trig_en, trig_sel);
      RS_DIN:  bus_rdata = elem_word(din_q);
      RS_DOUT: bus_rdata = elem_word(elem_out_i);
      default: bus_rdata = '0;
    endcase
  end

  // Upper write data bits are reserved; fold them into a sink
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:N_ELEM];

  la_trig_route #(.N_ELEM(N_ELEM)) i_trig (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_en   (trig_en),
    .cfg_sel  (trig_sel),
    .elem_out (elem_out_i),
    .start    (conv_start_o)
  );

  // R6: the trigger configuration is frozen once locked
  p_cfg_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable({trig_en, trig_sel}));

  // R6, R3: the input word still takes writes after locking
  p_din_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && wr_din) |=> (elem_in_o == $past(bus_wdata[N_ELEM-1:0])));

  // R10: unmapped offsets read as zero
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsel == RS_NONE) |-> (bus_rdata == '0));

  // R5: the lock offset reads as zero
  p_lock_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsel == RS_LOCK) |-> (bus_rdata == '0));
endmodule

// File: tb/test_la_ctrl_regs.sv
`timescale 1ns/1ps
module test_la_ctrl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] elem_out_i = '0;
  logic [15:0] elem_in_o;
  logic        conv_start_o;

  int total = 0;
  int bad = 0;

  // Cycle model state
  logic       m_en, m_lock, m_lvl_q, m_start;
  logic [3:0] m_sel;
  logic [15:0] m_din;

  always #5 clk = ~clk;

  la_ctrl_regs i_la_ctrl_regs (
    .clk, .rst_n, .bus_addr, .bus_we, .bus_wdata, .bus_rdata,
    .elem_out_i, .elem_in_o, .conv_start_o
  );

  function automatic logic [31:0] exp_read(input logic [7:0] a, input logic [15:0] eo);
    if (a == 8'h48) return {27'd0, m_en, m_sel};
    if (a == 8'h4C) return {16'd0, m_din};
    if (a == 8'h50) return {16'd0, eo};
    return 32'd0;
  endfunction

  function automatic string read_tag(input logic [7:0] a);
    if (a == 8'h48) return "R2";
    if (a == 8'h4C) return "R3";
    if (a == 8'h50) return "R4";
    if (a == 8'h54) return "R5";
    return "R10";
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_en = 0; m_lock = 0; m_lvl_q = 0; m_start = 0; m_sel = '0; m_din = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; elem_out_i = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  // One bus cycle: drive, compare against the model, then advance the model
  task automatic step(input logic [7:0] a, input logic we, input logic [31:0] wd,
                      input logic [15:0] eo, input string ptag);
    logic lvl;
    @(negedge clk);
    bus_addr = a; bus_we = we; bus_wdata = wd; elem_out_i = eo;
    #1;
    chk(read_tag(a), bus_rdata, exp_read(a, eo));
    chk(ptag, {31'd0, conv_start_o}, {31'd0, m_start});
    chk("R3", {16'd0, elem_in_o}, {16'd0, m_din});
    lvl = m_en && eo[m_sel];
    m_start = lvl && !m_lvl_q;
    m_lvl_q = lvl;
    if (we) begin
      if (a == 8'h48 && !m_lock) begin m_en = wd[4]; m_sel = wd[3:0]; end
      if (a == 8'h4C) m_din = wd[15:0];
      if (a == 8'h54 && wd[0]) m_lock = 1'b1;
    end
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] eo;
    model_reset();
    do_reset();

    // R1: reset state through every offset
    step(8'h48, 0, 0, 16'h0, "R1");
    chk("R1", bus_rdata, 32'h0);
    step(8'h4C, 0, 0, 16'h0, "R1");
    step(8'h50, 0, 0, 16'h0, "R1");
    step(8'h54, 0, 0, 16'h0, "R1");
    chk("R1", {31'd0, conv_start_o}, 32'h0);

    // R2: fields packed at bits 4 and 3:0
    step(8'h48, 1, 32'hFFFF_FFF5, 16'h0, "R8");
    step(8'h48, 0, 0, 16'h0, "R8");
    chk("R2", bus_rdata, 32'h15);

    // R3: input word, upper bits dropped
    step(8'h4C, 1, 32'hABCD_1234, 16'h0, "R8");
    step(8'h4C, 0, 0, 16'h0, "R8");
    chk("R3", bus_rdata, 32'h1234);
    chk("R3", {16'd0, elem_in_o}, 32'h1234);

    // R4: output view, write ignored
    step(8'h50, 1, 32'hFFFF_FFFF, 16'h5A5A, "R8");
    chk("R4", bus_rdata, 32'h5A5A);
    step(8'h50, 0, 0, 16'h0101, "R8");
    chk("R4", bus_rdata, 32'h0101);

    // R8: element 5 rising gives exactly one pulse (enable on, sel 5)
    step(8'h40, 0, 0, 16'h0000, "R8");
    step(8'h40, 0, 0, 16'h0020, "R8");
    step(8'h40, 0, 0, 16'h0020, "R8");
    chk("R8", {31'd0, conv_start_o}, 32'h1);
    step(8'h40, 0, 0, 16'h0020, "R8");
    chk("R8", {31'd0, conv_start_o}, 32'h0);

    // R9: only neighbours toggle
    for (int i = 0; i < 6; i++) step(8'h40, 0, 0, (i % 2) ? 16'hFFDF : 16'h0000, "R9");
    // R9: disable, then toggle the selected element
    step(8'h48, 1, 32'h05, 16'h0000, "R9");
    for (int i = 0; i < 6; i++) step(8'h40, 0, 0, (i % 2) ? 16'h0020 : 16'h0000, "R9");
    chk("R9", {31'd0, conv_start_o}, 32'h0);

    // R10: unmapped and unaligned writes change nothing
    step(8'h40, 1, 32'hFFFF_FFFF, 16'h0, "R8");
    step(8'h49, 1, 32'hFFFF_FFFF, 16'h0, "R8");
    step(8'h48, 0, 0, 16'h0, "R8");
    chk("R10", bus_rdata, 32'h05);

    // R7: first write of 0 does not lock
    step(8'h54, 1, 32'hFFFF_FFFE, 16'h0, "R8");
    step(8'h48, 1, 32'h1C, 16'h0, "R8");
    step(8'h48, 0, 0, 16'h0, "R8");
    chk("R7", bus_rdata, 32'h1C);

    // R5, R6: lock, then config dropped and input word still open
    step(8'h54, 1, 32'h1, 16'h0, "R8");
    chk("R5", bus_rdata, 32'h0);
    step(8'h48, 1, 32'h03, 16'h0, "R8");
    step(8'h4C, 1, 32'h0000_BEEF, 16'h0, "R8");
    step(8'h48, 0, 0, 16'h0, "R8");
    chk("R6", bus_rdata, 32'h1C);
    chk("R6", {16'd0, elem_in_o}, 32'hBEEF);

    // R7: a later write of 0 does not unlock
    step(8'h54, 1, 32'h0, 16'h0, "R8");
    step(8'h48, 1, 32'h07, 16'h0, "R8");
    step(8'h48, 0, 0, 16'h0, "R8");
    chk("R7", bus_rdata, 32'h1C);
    // locked config still triggers on element 12
    step(8'h40, 0, 0, 16'h1000, "R8");
    step(8'h40, 0, 0, 16'h1000, "R8");
    chk("R8", {31'd0, conv_start_o}, 32'h1);

    // Seeded random phase against the model
    do_reset();
    void'($urandom(32'd1234));
    eo = '0;
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] a;
      logic [31:0] wd;
      logic we;
      int pick;
      pick = $urandom_range(0, 9);
      case (pick)
        0, 1, 2: a = 8'h48;
        3, 4:    a = 8'h4C;
        5:       a = 8'h50;
        6:       a = 8'h54;
        7:       a = 8'h44;
        8:       a = 8'h4A;
        default: a = 8'($urandom);
      endcase
      we = ($urandom_range(0, 2) != 0);
      wd = $urandom;
      if (a == 8'h54 && $urandom_range(0, 7) != 0) wd[0] = 1'b0;
      if ($urandom_range(0, 3) == 0) eo = 16'($urandom);
      else eo[m_sel] = $urandom_range(0, 1) == 1;
      step(a, we, wd, eo, "R8");
      if (n == 2000) do_reset();
    end
    step(8'h40, 0, 0, eo, "R8");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule